// File: doc/BRIEF.md
# Clock-Gate Enable Observation Cell

This block gates the clock of a set of downstream register banks to save power. Each gate holds its enable in a latch that is open only while the free-running clock is low. The latched value is ANDed with the clock, so a gated clock can rise only on a full high phase. A test-enable input is ORed into every gate's enable, which lets a tester force all banks to clock during scan shift and capture. Each downstream bank is a mux-scan register with its own serial chain, and it clocks only through its gate.

Each gate also feeds an observation flop that runs on the ungated clock. In capture mode that flop samples the gate's latched enable on every clock edge. In shift mode the observation flops form their own scan chain, which does not depend on any gate. A gate stuck off silences its bank's chain. Its enable is still captured and shifted out on the observation chain, so the fault can be seen.

Top module: `cgo_enable_observer`

## Requirements
- R1: While `clk_i` is low, every bit of `gclk_o` is low.
- R2: When `func_en_i[i]` and `test_en_i` are both 0 at a rising edge of `clk_i`, bank i and `bank_scan_out_o[i]` keep their values across that edge.
- R3: When `func_en_i[i]` is 1 and `scan_en_i` is 0, bank i loads its slice of `bank_d_i` (bits [i*W +: W]) on the rising edge of `clk_i`. That bank's value is visible on the same slice of `bank_q_o`.
- R4: When `test_en_i` is 1, every gate is on whatever `func_en_i` holds, so every bank captures (with `scan_en_i`=0) or shifts (with `scan_en_i`=1).
- R5: A change of `func_en_i` while `clk_i` is high leaves `gclk_o` unchanged for the rest of that high phase. The new value takes effect from the next low phase.
- R6: With `scan_en_i`=0, observation flop i captures the gate's effective enable (`func_en_i[i]` OR `test_en_i`) on every rising edge of `clk_i`, whether the gate is on or off.
- R7: With `scan_en_i`=1, the observation chain shifts on every rising edge of `clk_i`, even when every gate is off. `obs_scan_in_i` enters flop 0, flop k takes the value of flop k-1, and `obs_scan_out_o` is flop N-1.
- R8: With `scan_en_i`=1 and gate i on, bank i shifts. `bank_scan_in_i[i]` enters bit 0, bit k takes bit k-1, and `bank_scan_out_o[i]` is bit W-1.
- R9: When `rst_ni` is low, every bank bit and every observation flop is cleared to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_en_i | input | N | Functional enable, one bit per gate |
| test_en_i | input | 1 | Forces every gate on |
| scan_en_i | input | 1 | 1 selects shift and 0 selects capture, for all chains |
| bank_d_i | input | N*W | Capture data for the banks; slice i goes to bank i |
| bank_scan_in_i | input | N | Serial input of each bank chain |
| obs_scan_in_i | input | 1 | Serial input of the observation chain |
| gclk_o | output | N | Gated clock of each bank |
| bank_q_o | output | N*W | Bank contents; slice i is bank i |
| bank_scan_out_o | output | N | Serial output of each bank chain |
| obs_scan_out_o | output | 1 | Serial output of the observation chain |

## Verification
A wrong latched enable shows up in two places. On `gclk_o` it appears within the same clock phase. On `bank_q_o` it appears one rising edge later, as a bank that loads when it should hold or holds when it should load. A wrong observation flop appears at `obs_scan_out_o` after one capture edge for the last flop, and after up to N-1 further shift edges for the others. A broken shift path in a bank corrupts `bank_scan_out_o` within W shift edges.

// File: rtl/cgo_pkg.sv
package cgo_pkg;
  localparam int unsigned CGO_GATES_DEF  = 2;
  localparam int unsigned CGO_BANK_W_DEF = 4;

  // Selects the next value of a mux-scan register of width 1..n.
  function automatic logic [63:0] cgo_scan_next(input logic [63:0] cur,
                                                input logic [63:0] cap,
                                                input logic        sin,
                                                input logic        shift,
                                                input int unsigned n);
    logic [63:0] r;
    r = cap;
    if (shift) begin
      r = '0;
      r[0] = sin;
      for (int unsigned k = 1; k < n; k++) r[k] = cur[k-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/cgo_latch_gate.sv
module cgo_latch_gate (
  input  logic clk_i,
  input  logic func_en_i,
  input  logic test_en_i,
  output logic en_latched_o,
  output logic gclk_o
);
  logic en_req;
  assign en_req = func_en_i | test_en_i;

  // Open only in the low phase: the enable is frozen for the whole high phase.
  always_latch begin
    if (!clk_i) en_latched_o <= en_req;
  end

  assign gclk_o = clk_i & en_latched_o;
endmodule

// File: rtl/cgo_gated_bank.sv
module cgo_gated_bank #(
  parameter int unsigned W = cgo_pkg::CGO_BANK_W_DEF
) (
  input  logic         gclk_i,
  input  logic         rst_ni,
  input  logic         scan_en_i,
  input  logic         scan_in_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         scan_out_o
);
  logic [W-1:0] q, nxt;

  always_comb begin
    nxt = d_i;
    if (scan_en_i) begin
      nxt[0] = scan_in_i;
      for (int unsigned k = 1; k < W; k++) nxt[k] = q[k-1];
    end
  end

  always_ff @(posedge gclk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o        = q;
  assign scan_out_o = q[W-1];
endmodule

// File: rtl/cgo_obs_chain.sv
module cgo_obs_chain #(
  parameter int unsigned N = cgo_pkg::CGO_GATES_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scan_en_i,
  input  logic         scan_in_i,
  input  logic [N-1:0] probe_i,
  output logic         scan_out_o
);
  logic [N-1:0] obs, nxt;

  always_comb begin
    nxt = probe_i;
    if (scan_en_i) begin
      nxt[0] = scan_in_i;
      for (int unsigned k = 1; k < N; k++) nxt[k] = obs[k-1];
    end
  end

  // Free-running clock: never gated, so it can report a silent gate.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) obs <= '0;
    else         obs <= nxt;
  end

  assign scan_out_o = obs[N-1];

  assert_obs_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> obs == $past(probe_i));

  assert_obs_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> obs[0] == $past(scan_in_i));
endmodule

// File: rtl/cgo_enable_observer.sv
module cgo_enable_observer #(
  parameter int unsigned N = cgo_pkg::CGO_GATES_DEF,
  parameter int unsigned W = cgo_pkg::CGO_BANK_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   func_en_i,
  input  logic           test_en_i,
  input  logic           scan_en_i,
  input  logic [N*W-1:0] bank_d_i,
  input  logic [N-1:0]   bank_scan_in_i,
  input  logic           obs_scan_in_i,
  output logic [N-1:0]   gclk_o,
  output logic [N*W-1:0] bank_q_o,
  output logic [N-1:0]   bank_scan_out_o,
  output logic           obs_scan_out_o
);
  localparam int unsigned TOTAL_BITS = N * W;

  logic [N-1:0] en_latched;

  for (genvar g = 0; g < N; g++) begin : g_gate
    cgo_latch_gate u_gate (
      .clk_i        (clk_i),
      .func_en_i    (func_en_i[g]),
      .test_en_i    (test_en_i),
      .en_latched_o (en_latched[g]),
      .gclk_o       (gclk_o[g])
    );

    cgo_gated_bank #(.W(W)) u_bank (
      .gclk_i     (gclk_o[g]),
      .rst_ni     (rst_ni),
      .scan_en_i  (scan_en_i),
      .scan_in_i  (bank_scan_in_i[g]),
      .d_i        (bank_d_i[g*W +: W]),
      .q_o        (bank_q_o[g*W +: W]),
      .scan_out_o (bank_scan_out_o[g])
    );

    assert_bank_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(func_en_i[g] | test_en_i) |=> $stable(bank_q_o[g*W +: W]));

    assert_bank_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_en_i[g] && !scan_en_i) |=> bank_q_o[g*W +: W] == $past(bank_d_i[g*W +: W]));

    assert_test_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && !scan_en_i) |=> bank_q_o[g*W +: W] == $past(bank_d_i[g*W +: W]));

    assert_bank_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((func_en_i[g] || test_en_i) && scan_en_i) |=> bank_q_o[g*W] == $past(bank_scan_in_i[g]));
  end

  cgo_obs_chain #(.N(N)) u_obs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_en_i  (scan_en_i),
    .scan_in_i  (obs_scan_in_i),
    .probe_i    (en_latched),
    .scan_out_o (obs_scan_out_o)
  );

  initial begin
    assert_size_ok: assert (TOTAL_BITS >= 1);
  end
endmodule

// File: tb/cgo_enable_observer_test.sv
module cgo_enable_observer_test;
  localparam int N = 2;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_ni;
  logic [N-1:0]   func_en;
  logic           test_en, scan_en, obs_si;
  logic [N*W-1:0] bank_d;
  logic [N-1:0]   bank_si;
  logic [N-1:0]   gclk;
  logic [N*W-1:0] bank_q;
  logic [N-1:0]   bank_so;
  logic           obs_so;

  cgo_enable_observer #(.N(N), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .func_en_i(func_en), .test_en_i(test_en),
    .scan_en_i(scan_en), .bank_d_i(bank_d), .bank_scan_in_i(bank_si),
    .obs_scan_in_i(obs_si), .gclk_o(gclk), .bank_q_o(bank_q),
    .bank_scan_out_o(bank_so), .obs_scan_out_o(obs_so)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    logic [N*W-1:0] q;
    logic [N-1:0]   so;
    logic           oso;
    string          req;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] mbank [N];
  logic [N-1:0] mobs;

  task automatic check1(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] fen, input logic ten, input logic sen,
                      input logic [N*W-1:0] d, input logic [N-1:0] bsi,
                      input logic osi, input string req, input bit probe = 0);
    logic [N-1:0] eff, nobs;
    logic [W-1:0] nb;
    exp_t e;
    @(negedge clk);
    func_en = fen; test_en = ten; scan_en = sen; bank_d = d;
    bank_si = bsi; obs_si = osi;
    eff = fen | {N{ten}};
    for (int i = 0; i < N; i++) begin
      if (eff[i]) begin
        if (sen) begin
          nb = '0;
          nb[0] = bsi[i];
          for (int k = 1; k < W; k++) nb[k] = mbank[i][k-1];
          mbank[i] = nb;
        end else begin
          mbank[i] = d[i*W +: W];
        end
      end
    end
    if (sen) begin
      nobs = '0;
      nobs[0] = osi;
      for (int k = 1; k < N; k++) nobs[k] = mobs[k-1];
    end else begin
      nobs = eff;
    end
    mobs = nobs;
    for (int i = 0; i < N; i++) begin
      e.q[i*W +: W] = mbank[i];
      e.so[i] = mbank[i][W-1];
    end
    e.oso = mobs[N-1];
    e.req = req;
    sb.push_back(e);
    #1 check1("R1 gclk low in low phase", 64'(gclk), 64'(0));
    if (probe) begin
      @(posedge clk);
      #1 func_en = ~fen;
      #2 check1("R5 gclk held during high phase", 64'(gclk), 64'(eff));
    end
  endtask

  // Monitor: pops one expectation per rising edge, after the edge settles.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check1({e.req, " bank_q"},   64'(bank_q),  64'(e.q));
        check1({e.req, " bank_so"},  64'(bank_so), 64'(e.so));
        check1({e.req, " obs_so"},   64'(obs_so),  64'(e.oso));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; func_en = '1; test_en = 1'b0; scan_en = 1'b0;
    bank_d = '1; bank_si = '0; obs_si = 1'b0;
    for (int i = 0; i < N; i++) mbank[i] = '0;
    mobs = '0;
    repeat (3) @(negedge clk);
    check1("R9 bank_q in reset", 64'(bank_q), 64'(0));
    check1("R9 obs_so in reset", 64'(obs_so), 64'(0));
    func_en = '0; bank_d = '0;
    rst_ni = 1'b1;

    step(2'b00, 0, 0, 8'hA5, 2'b00, 0, "R2");
    step(2'b01, 0, 0, 8'h3C, 2'b00, 0, "R3");
    step(2'b10, 0, 0, 8'h96, 2'b00, 0, "R3", 1);
    step(2'b00, 0, 1, 8'hFF, 2'b11, 1, "R7");
    step(2'b00, 0, 1, 8'h00, 2'b11, 0, "R7");
    step(2'b11, 0, 0, 8'h5A, 2'b00, 0, "R6");
    step(2'b00, 1, 0, 8'hE7, 2'b00, 0, "R4");
    step(2'b00, 1, 1, 8'h00, 2'b01, 1, "R8");
    step(2'b00, 1, 1, 8'h00, 2'b10, 0, "R8");
    step(2'b00, 1, 1, 8'h00, 2'b11, 1, "R8");
    step(2'b00, 1, 1, 8'h00, 2'b00, 1, "R8");
    step(2'b10, 0, 1, 8'h00, 2'b11, 0, "R8");
    step(2'b01, 0, 0, 8'hC3, 2'b00, 0, "R6", 1);
    step(2'b00, 0, 0, 8'h11, 2'b00, 0, "R2");
    repeat (3) @(negedge clk);

    rst_ni = 1'b0;
    #1;
    check1("R9 bank_q after async reset", 64'(bank_q), 64'(0));
    check1("R9 bank_so after async reset", 64'(bank_so), 64'(0));
    check1("R9 obs_so after async reset", 64'(obs_so), 64'(0));
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule